// File: doc/BRIEF.md
# Sequenced-Key Watchdog Timer

This block is a computer-operating-properly watchdog. While it is running, it counts clock cycles toward a time-out. Software keeps it quiet by writing a two-word key to a service register. The opening word is 0x0055 and the closing word is 0x00AA, and they must arrive in that order. A completed key clears the count and starts a fresh period. If the count reaches the end of the period, or if any other value is written to the register, the block issues a reset request.

A 3-bit rate input selects the period. Code k (from 1 to 7) gives 2^(BASE_LOG2 + STEP_LOG2·k) cycles, which is 2^(14+2k) with the default parameters. Code 0, or a low enable, stops the watchdog. In windowed mode, a key completed too early is treated as a fault. The reset request is a single-cycle pulse, and the count starts again from zero after it.

Top module: `key_watchdog`

## Requirements
- R1: A write of 0x0055 followed later by a write of 0x00AA (with no other register write between them) is a service. The count returns to zero on the closing write's edge, and the next time-out comes a full period after that edge.
- R2: With the watchdog active and no service, `rst_req` goes high exactly P clock edges after activation or after the last restart. P = 2^(BASE_LOG2 + STEP_LOG2·k) and k = `rate_sel`.
- R3: While active, writing any value other than 0x0055 or 0x00AA (all DATA_W bits are compared) raises `rst_req` for the cycle right after the write edge.
- R4: A write of 0x00AA that is not preceded by an unconsumed 0x0055 is ignored. It does not restart the count and it does not raise a reset.
- R5: Repeated writes of 0x0055 keep the key armed, so a later 0x00AA still completes a service.
- R6: With `window_en` high, a key completed while the count is below 3·P/4 raises `rst_req` on the next cycle. A key completed at a count of 3·P/4 or above is a normal service.
- R7: `rst_req` lasts one cycle. The count is reloaded to zero at the fault edge, so the next time-out follows P edges after the pulse.
- R8: When `enable` is low or `rate_sel` is 0, the block is inactive. No reset is raised, writes are ignored, the count is held at zero, and counting resumes from zero on activation.
- R9: After `rst_n` is asserted, `rst_req` is low and the key is disarmed.
- R10: A key completed on the final cycle of the period (count P−1) takes precedence over the time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Watchdog enable |
| rate_sel | input | RATE_W | Period code; 0 stops the watchdog |
| window_en | input | 1 | Reject keys completed in the first three quarters of the period |
| wr_en | input | 1 | Service-register write strobe |
| wr_data | input | DATA_W | Service-register write data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with BASE_LOG2=3 and STEP_LOG2=1. With these values, rate code 1 gives a 16-cycle period and code 2 gives a 32-cycle period. Every time-out, the window boundary at count 12, and the last-cycle service can therefore be reached in a few dozen cycles and checked edge by edge. The key values, the data width, and the rate decoding keep their default structure.

// File: rtl/kw_pkg.sv
package kw_pkg;

  typedef enum logic [1:0] {
    KW_NONE  = 2'd0,
    KW_OPEN  = 2'd1,
    KW_CLOSE = 2'd2,
    KW_BAD   = 2'd3
  } kw_word_e;

  // Period length in cycles for rate code k.
  function automatic logic [31:0] kw_period(input int unsigned rate,
                                            input int unsigned base,
                                            input int unsigned step);
    return 32'd1 << (base + step * rate);
  endfunction

  // First count value at which a windowed key is accepted (3/4 of period).
  function automatic logic [31:0] kw_window_open(input logic [31:0] period);
    return period - (period >> 2);
  endfunction

endpackage

// File: rtl/kw_word_classify.sv
module kw_word_classify
  import kw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 'h0055,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 'h00AA
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output kw_word_e          kind
);

  always_comb begin
    if (!wr_en)                  kind = KW_NONE;
    else if (wr_data == KEY_OPEN)  kind = KW_OPEN;
    else if (wr_data == KEY_CLOSE) kind = KW_CLOSE;
    else                         kind = KW_BAD;
  end

endmodule

// File: rtl/kw_key_tracker.sv
module kw_key_tracker
  import kw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     expire,
  input  kw_word_e kind,
  output logic     armed,
  output logic     done,
  output logic     bad
);

  assign done = active && armed && (kind == KW_CLOSE);
  assign bad  = active && (kind == KW_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed <= 1'b0;
    else if (!active)            armed <= 1'b0;
    else if (bad || done)        armed <= 1'b0;
    else if (kind == KW_OPEN)    armed <= 1'b1;
    else if (expire)             armed <= 1'b0;
  end

endmodule

// File: rtl/kw_period_timer.sv
module kw_period_timer
  import kw_pkg::*;
#(
  parameter int RATE_W    = 3,
  parameter int BASE_LOG2 = 14,
  parameter int STEP_LOG2 = 2,
  localparam int CNT_W    = BASE_LOG2 + STEP_LOG2 * ((1 << RATE_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate_sel,
  output logic [CNT_W-1:0]  cnt,
  output logic              expire,
  output logic              early
);

  logic [31:0] period_w;
  logic [31:0] open_w;
  logic [31:0] cnt_w;

  assign period_w = kw_period(int'(rate_sel), BASE_LOG2, STEP_LOG2);
  assign open_w   = kw_window_open(period_w);
  assign cnt_w    = 32'(cnt);

  assign expire = active && (cnt_w >= period_w - 32'd1);
  assign early  = cnt_w < open_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!active || restart)  cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import kw_pkg::*;
#(
  parameter int RATE_W    = 3,
  parameter int DATA_W    = 16,
  parameter int BASE_LOG2 = 14,
  parameter int STEP_LOG2 = 2,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 'h0055,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 'h00AA,
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * ((1 << RATE_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              window_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req
);

  kw_word_e         kind;
  logic             active;
  logic             key_armed, key_done, key_bad;
  logic             expire, early;
  logic             svc_ok, win_fault, fault, restart;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign active = enable && (rate_sel != '0);

  kw_word_classify #(
    .DATA_W(DATA_W), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
  ) u_classify (
    .wr_en(wr_en), .wr_data(wr_data), .kind(kind)
  );

  kw_key_tracker u_tracker (
    .clk(clk), .rst_n(rst_n), .active(active), .expire(expire),
    .kind(kind), .armed(key_armed), .done(key_done), .bad(key_bad)
  );

  kw_period_timer #(
    .RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(restart),
    .rate_sel(rate_sel), .cnt(cnt), .expire(expire), .early(early)
  );

  assign win_fault = key_done && window_en && early;
  assign svc_ok    = key_done && !win_fault;
  assign fault     = key_bad || win_fault || (expire && !key_done);
  assign restart   = svc_ok || fault;
  assign cnt_zero  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= fault;
  end

endmodule

// File: rtl/kw_checker.sv
module kw_checker (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic window_en,
  input logic wr_en,
  input logic key_armed,
  input logic key_done,
  input logic key_bad,
  input logic expire,
  input logic early,
  input logic cnt_zero,
  input logic rst_req
);

  p_service_r1: assert property (@(posedge clk) disable iff (!rst_n)
    key_done && !(window_en && early) |=> cnt_zero && !rst_req);

  p_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !key_done |=> rst_req);

  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active && key_bad |=> rst_req);

  p_lone_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active && wr_en && !key_armed && !key_bad && !expire |=> !rst_req);

  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_done && window_en && early |=> rst_req);

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt_zero);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rst_req && cnt_zero);

endmodule

bind key_watchdog kw_checker u_kw_checker (.*);

// File: tb/test_key_watchdog.sv
module test_key_watchdog;

  localparam int BASE = 3;
  localparam int STEP = 1;
  localparam logic [15:0] K_OPEN  = 16'h0055;
  localparam logic [15:0] K_CLOSE = 16'h00AA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [2:0] rate_sel = '0;
  logic window_en = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic rst_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  key_watchdog #(.BASE_LOG2(BASE), .STEP_LOG2(STEP)) i_key_watchdog (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
    .window_en(window_en), .wr_en(wr_en), .wr_data(wr_data), .rst_req(rst_req)
  );

  function automatic int per(input int k);
    return 1 << (BASE + STEP * k);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s rst_req actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic restart_dut(input logic [2:0] k, input logic win);
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; rate_sel = '0; window_en = 1'b0; wr_en = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    enable = 1'b1; rate_sel = k; window_en = win;
  endtask

  // Expects a pulse P edges from now (count currently zero).
  task automatic expect_pulse(input string tag, input int p);
    tick(p - 1); check(tag, rst_req, 1'b0);
    tick(1);     check(tag, rst_req, 1'b1);
    tick(1);     check(tag, rst_req, 1'b0);
  endtask

  task automatic t_reset_r9();
    restart_dut(3'd0, 1'b0);
    check("R9 reset", rst_req, 1'b0);
    rate_sel = 3'd1;
    wr(K_CLOSE);
    check("R9 disarmed after reset", rst_req, 1'b0);
    expect_pulse("R9 close after reset not a service", per(1) - 1);
  endtask

  task automatic t_timeout_r2_r7();
    restart_dut(3'd1, 1'b0);
    expect_pulse("R2 period k=1", per(1));
    tick(per(1) - 2); check("R7 reload", rst_req, 1'b0);
    tick(1);          check("R7 second pulse", rst_req, 1'b1);
    restart_dut(3'd2, 1'b0);
    expect_pulse("R2 period k=2", per(2));
  endtask

  task automatic t_service_r1();
    restart_dut(3'd1, 1'b0);
    tick(10);
    wr(K_OPEN);
    wr(K_CLOSE);
    check("R1 service no reset", rst_req, 1'b0);
    expect_pulse("R1 restart", per(1));
  endtask

  task automatic t_bad_r3();
    restart_dut(3'd1, 1'b0);
    tick(3);
    wr(16'h1234);
    check("R3 bad value", rst_req, 1'b1);
    tick(1); check("R3 single pulse", rst_req, 1'b0);
    restart_dut(3'd1, 1'b0);
    wr(K_OPEN);
    wr(16'h0155);
    check("R3 upper bits differ", rst_req, 1'b1);
  endtask

  task automatic t_lone_close_r4();
    restart_dut(3'd1, 1'b0);
    tick(5);
    wr(K_CLOSE);
    check("R4 lone close no reset", rst_req, 1'b0);
    tick(per(1) - 1 - 6); check("R4 no restart", rst_req, 1'b0);
    tick(1);              check("R4 original timeout", rst_req, 1'b1);
  endtask

  task automatic t_double_open_r5();
    restart_dut(3'd1, 1'b0);
    wr(K_OPEN);
    wr(K_OPEN);
    wr(K_CLOSE);
    check("R5 double open", rst_req, 1'b0);
    expect_pulse("R5 service restart", per(1));
  endtask

  task automatic t_window_r6();
    restart_dut(3'd1, 1'b1);
    tick(5);
    wr(K_OPEN);
    wr(K_CLOSE);
    check("R6 early key", rst_req, 1'b1);
    restart_dut(3'd1, 1'b1);
    tick(10);
    wr(K_OPEN);
    wr(K_CLOSE);
    check("R6 key at count 11", rst_req, 1'b1);
    restart_dut(3'd1, 1'b1);
    tick(11);
    wr(K_OPEN);
    wr(K_CLOSE);
    check("R6 key at count 12 accepted", rst_req, 1'b0);
    expect_pulse("R6 restart after window", per(1));
  endtask

  task automatic t_idle_r8();
    restart_dut(3'd1, 1'b0);
    enable = 1'b0;
    wr(16'hDEAD);
    check("R8 disabled write ignored", rst_req, 1'b0);
    tick(40); check("R8 disabled no timeout", rst_req, 1'b0);
    enable = 1'b1; rate_sel = 3'd0;
    wr(16'hBEEF);
    tick(40); check("R8 rate zero idle", rst_req, 1'b0);
    rate_sel = 3'd1;
    expect_pulse("R8 count from zero", per(1));
  endtask

  task automatic t_last_cycle_r10();
    restart_dut(3'd1, 1'b0);
    tick(per(1) - 2);
    wr(K_OPEN);
    wr(K_CLOSE);
    check("R10 service on last cycle", rst_req, 1'b0);
    expect_pulse("R10 restart", per(1));
  endtask

  initial begin
    t_reset_r9();
    t_timeout_r2_r7();
    t_service_r1();
    t_bad_r3();
    t_lone_close_r4();
    t_double_open_r5();
    t_window_r6();
    t_idle_r8();
    t_last_cycle_r10();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        #(20 * 20000);
        total++; bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule